// File: doc/BRIEF.md
# Thermometer-Pointer Round-Robin Arbiter

This block shares one resource among N requesters. Each cycle it looks at an N-bit request vector and returns a one-hot grant that names one winner. Fairness comes from rotating priority. The input that was just served becomes the lowest-priority input for the next arbitration. The next input above it, wrapping from the top index back to index 0, becomes the highest-priority input.

The priority state is not kept as a binary index. It is kept as a thermometer mask: every position strictly above the last winner holds a one, and every other position holds a zero. The mask divides the requests into an upper group (the requests that fall under the mask) and the full request vector. A Kogge-Stone prefix-OR network of logarithmic depth finds the lowest set bit in each group. The grant comes from the upper group when that group is non-empty. Otherwise it comes from the full vector, which produces the wraparound.

The grant is combinational from the request vector and the mask. The mask advances only when the consumer accepts the grant through a grant-enable input. A synchronous reset clears the mask so that input 0 starts with the highest priority.

Top module: `rrThermoArbiter`

## Requirements
- R1: Whenever at least one request bit is set, exactly one grant bit is set in the same cycle.
- R2: A grant bit is only ever set at a position whose request bit is also set.
- R3: After reset the mask is all zeros, so the lowest-index active request wins.
- R4: On a clock edge with grantEn high and a request present, the mask loads ones at exactly the positions strictly above the granted index. The granted input therefore becomes the lowest priority, and the search then begins one index above it.
- R5: When no request lies above the last winner, the grant wraps to the lowest-index active request.
- R6: With grantEn low, the mask keeps its value, so a repeated request pattern receives the same grant.
- R7: With an all-zero request vector, the grant is all zeros, anyGrant is low, and the mask holds even when grantEn is high.
- R8: anyGrant is high exactly when at least one request bit is set.
- R9: The block builds and arbitrates correctly for any N of 2 or more, including values that are not powers of two (exercised at 5 and 54 as well as 8).
- R10: A synchronous reset clears the mask to zeros, and it takes precedence over a grant accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req | input | N | Request vector, bit i from requester i |
| grantEn | input | 1 | High when the current grant is accepted, which advances the pointer |
| grant | output | N | One-hot grant, all zeros when idle |
| anyGrant | output | 1 | High when a grant is issued |

## Verification
Two pointer actions can fall in the same cycle: a reset that clears the mask, and an accepted grant that loads a new mask. The bench forces this collision by raising reset while requests are present and grantEn is high. It then applies an all-ones request vector and expects input 0 to win, which is only correct if the clear took precedence over the load. A second overlap is an edge with grantEn high but no requests. That case is judged by whether the next grant still follows the old rotation.

// File: rtl/rrArbPkg.sv
package rrArbPkg;

  // Strobes from control to the pointer datapath
  typedef struct packed {
    logic clearPtr;  // synchronous clear of the thermometer mask
    logic loadPtr;   // load next mask from current grant
  } ptrStrobes_t;

endpackage

// File: rtl/prefixOr.sv
// Kogge-Stone inclusive prefix OR: orOut[i] = |bitsIn[i:0]
module prefixOr #(
  parameter int W = 8
) (
  input  logic [W-1:0] bitsIn,
  output logic [W-1:0] orOut
);
  localparam int Levels = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0] stage [0:Levels];

  assign stage[0] = bitsIn;

  for (genvar lv = 0; lv < Levels; lv++) begin : gLevel
    localparam int Span = 1 << lv;
    for (genvar i = 0; i < W; i++) begin : gBit
      if (i >= Span) begin : gCombine
        assign stage[lv+1][i] = stage[lv][i] | stage[lv][i-Span];
      end else begin : gPass
        assign stage[lv+1][i] = stage[lv][i];
      end
    end
  end

  assign orOut = stage[Levels];
endmodule

// File: rtl/rrControl.sv
// Control: turns reset and the accept handshake into pointer strobes
module rrControl
  import rrArbPkg::*;
(
  input  logic        rst,
  input  logic        grantEn,
  input  logic        anyHit,
  output ptrStrobes_t strobes
);
  always_comb begin
    strobes          = '0;
    strobes.clearPtr = rst;
    // reset wins over an accepted grant in the same cycle
    strobes.loadPtr  = !rst && grantEn && anyHit;
  end
endmodule

// File: rtl/rrDatapath.sv
// Datapath: thermometer mask, two-group prefix search, grant select
module rrDatapath
  import rrArbPkg::*;
#(
  parameter int N = 8
) (
  input  logic        clk,
  input  ptrStrobes_t strobes,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         anyHit,
  output logic [N-1:0] ptrMask
);
  logic [N-1:0] ptrQ;
  logic [N-1:0] maskedReq;
  logic [N-1:0] preHi, preAll;
  logic [N-1:0] exclHi, exclAll;
  logic [N-1:0] grantHi, grantAll;
  logic [N-1:0] nextMask;
  logic         hasHi;

  assign maskedReq = req & ptrQ;

  prefixOr #(.W(N)) uPreHi  (.bitsIn(maskedReq), .orOut(preHi));
  prefixOr #(.W(N)) uPreAll (.bitsIn(req),       .orOut(preAll));

  assign hasHi  = preHi[N-1];
  assign anyHit = preAll[N-1];

  // exclusive prefix: OR of strictly lower positions
  assign exclHi  = {preHi[N-2:0], 1'b0};
  assign exclAll = {preAll[N-2:0], 1'b0};

  assign grantHi  = maskedReq & ~exclHi;
  assign grantAll = req & ~exclAll;
  assign grant    = hasHi ? grantHi : grantAll;

  // ones strictly above the winner: prefix OR of the grant shifted up
  prefixOr #(.W(N)) uPreNext (.bitsIn({grant[N-2:0], 1'b0}), .orOut(nextMask));

  always_ff @(posedge clk) begin
    if (strobes.clearPtr)     ptrQ <= '0;
    else if (strobes.loadPtr) ptrQ <= nextMask;
  end

  assign ptrMask = ptrQ;
endmodule

// File: rtl/rrThermoArbiter.sv
module rrThermoArbiter
  import rrArbPkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  input  logic         grantEn,
  output logic [N-1:0] grant,
  output logic         anyGrant
);
  ptrStrobes_t  strobes;
  logic         anyHit;
  logic [N-1:0] ptrMask;

  rrControl uCtl (
    .rst     (rst),
    .grantEn (grantEn),
    .anyHit  (anyHit),
    .strobes (strobes)
  );

  rrDatapath #(.N(N)) uDp (
    .clk     (clk),
    .strobes (strobes),
    .req     (req),
    .grant   (grant),
    .anyHit  (anyHit),
    .ptrMask (ptrMask)
  );

  assign anyGrant = anyHit;
endmodule

// File: rtl/rrArbChecker.sv
module rrArbChecker #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] req,
  input logic         grantEn,
  input logic [N-1:0] grant,
  input logic         anyGrant,
  input logic [N-1:0] ptrMask
);
  logic [N-1:0] invMask;
  logic [N-1:0] expNext;

  always_comb begin
    invMask = ~ptrMask;
    expNext = ~((grant << 1) - 1'b1);
  end

  a_r1_onehot: assert property (@(posedge clk) disable iff (rst)
    anyGrant |-> ($countones(grant) == 1));

  a_r2_subset: assert property (@(posedge clk) disable iff (rst)
    (grant & ~req) == '0);

  a_r8_any: assert property (@(posedge clk) disable iff (rst)
    anyGrant == (|req));

  a_r7_idle: assert property (@(posedge clk) disable iff (rst)
    (req == '0) |-> (grant == '0));

  a_r4_thermo: assert property (@(posedge clk) disable iff (rst)
    (invMask & (invMask + 1'b1)) == '0);

  a_r4_load: assert property (@(posedge clk) disable iff (rst)
    (grantEn && anyGrant) |=> (ptrMask == $past(expNext)));

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (!grantEn || !anyGrant) |=> $stable(ptrMask));

  a_r10_clear: assert property (@(posedge clk)
    rst |=> (ptrMask == '0));
endmodule

bind rrThermoArbiter rrArbChecker #(.N(N)) uChk (
  .clk      (clk),
  .rst      (rst),
  .req      (req),
  .grantEn  (grantEn),
  .grant    (grant),
  .anyGrant (anyGrant),
  .ptrMask  (ptrMask)
);

// File: tb/rrThermoArbiter_test.sv
// One lane per tested width; each holds its own uut and reference model
module rrArbLane #(
  parameter int N = 8,
  parameter int unsigned SEED = 1
) (
  input  logic clk,
  output logic done,
  output int   nChecks,
  output int   nFails
);
  logic         rst;
  logic [N-1:0] req;
  logic         grantEn;
  logic [N-1:0] grant;
  logic         anyGrant;
  int           startIdx;

  rrThermoArbiter #(.N(N)) uut (
    .clk(clk), .rst(rst), .req(req), .grantEn(grantEn),
    .grant(grant), .anyGrant(anyGrant)
  );

  function automatic logic [N-1:0] modelGrant(input logic [N-1:0] r, input int s);
    logic [N-1:0] g = '0;
    for (int k = 0; k < N; k++) begin
      int idx = (s + k) % N;
      if (r[idx]) begin
        g[idx] = 1'b1;
        return g;
      end
    end
    return g;
  endfunction

  function automatic int indexOf(input logic [N-1:0] g);
    for (int i = 0; i < N; i++) if (g[i]) return i;
    return 0;
  endfunction

  function automatic logic [N-1:0] randReq(input int density);
    logic [N-1:0] r = '0;
    for (int i = 0; i < N; i++) r[i] = (($urandom % 100) < density);
    return r;
  endfunction

  task automatic step(input logic [N-1:0] r, input logic en, input logic rs,
                      input string tag, input bit chk);
    logic [N-1:0] expG;
    @(negedge clk);
    req = r; grantEn = en; rst = rs;
    #1;
    expG = modelGrant(r, startIdx);
    if (chk) begin
      nChecks++;
      if (grant !== expG || anyGrant !== (|r)) begin
        nFails++;
        $display("FAIL %s N=%0d req=%h: grant=%h any=%b expected grant=%h any=%b",
                 tag, N, r, grant, anyGrant, expG, |r);
      end
    end
    @(posedge clk);
    if (rs) startIdx = 0;
    else if (en && (|r)) startIdx = (indexOf(expG) + 1) % N;
  endtask

  initial begin
    logic [N-1:0] held;
    done = 0; nChecks = 0; nFails = 0;
    rst = 1; req = '0; grantEn = 0; startIdx = 0;
    void'($urandom(SEED));
    step('0, 1'b0, 1'b1, "reset", 1'b0);
    step('0, 1'b0, 1'b1, "reset", 1'b0);
    // R7 R8: idle output after reset
    step('0, 1'b1, 1'b0, "R7 R8 idle", 1'b1);
    // R3: lowest index wins first; R4 R5: full rotation with wrap
    for (int i = 0; i < N + 3; i++) step('1, 1'b1, 1'b0, "R3 R4 R5 rotate", 1'b1);
    // R1 R2: single requests
    for (int i = 0; i < N; i++) step(N'(1) << i, 1'b1, 1'b0, "R1 R2 single", 1'b1);
    // R5: only a request below the last winner remains -> wrap
    step(N'(1) << (N - 1), 1'b1, 1'b0, "R5 top", 1'b1);
    step(N'(1) | (N'(1) << 1), 1'b1, 1'b0, "R5 wrap", 1'b1);
    // R6: grantEn low keeps priority
    held = randReq(60) | N'(1);
    for (int i = 0; i < 4; i++) step(held, 1'b0, 1'b0, "R6 hold", 1'b1);
    step('1, 1'b1, 1'b0, "R6 after hold", 1'b1);
    // R7: no requests with grantEn high, pointer holds
    for (int i = 0; i < 3; i++) step('0, 1'b1, 1'b0, "R7 no request", 1'b1);
    step('1, 1'b1, 1'b0, "R7 pointer held", 1'b1);
    // R10: reset collides with an accepted grant
    step('1, 1'b1, 1'b0, "R10 pre", 1'b1);
    step('1, 1'b1, 1'b1, "R10 collide", 1'b1);
    step('1, 1'b1, 1'b0, "R10 restart at 0", 1'b1);
    // R1 R2 R4 R9: random mix
    for (int i = 0; i < 400; i++) begin
      int dens = (i % 4 == 0) ? 5 : ((i % 4 == 1) ? 30 : 70);
      step(randReq(dens), (($urandom % 4) != 0), 1'b0, "R1 R2 R4 R9 random", 1'b1);
    end
    done = 1;
  end
endmodule

module rrThermoArbiter_test;
  logic clk = 0;
  always #5 clk = ~clk;

  logic done5, done8, done54;
  int c5, f5, c8, f8, c54, f54;

  rrArbLane #(.N(5),  .SEED(11)) lane5  (.clk(clk), .done(done5),  .nChecks(c5),  .nFails(f5));
  rrArbLane #(.N(8),  .SEED(22)) lane8  (.clk(clk), .done(done8),  .nChecks(c8),  .nFails(f8));
  rrArbLane #(.N(54), .SEED(33)) lane54 (.clk(clk), .done(done54), .nChecks(c54), .nFails(f54));

  initial begin
    int cycles = 0;
    int wdFail = 0;
    while (!(done5 === 1'b1 && done8 === 1'b1 && done54 === 1'b1) && cycles < 50000) begin
      @(posedge clk);
      cycles++;
    end
    if (cycles >= 50000) begin
      wdFail = 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below 50000", cycles);
    end
    #1;
    $display("  [TB] %0d tests run, %0d failed", c5 + c8 + c54 + wdFail, f5 + f8 + f54 + wdFail);
    $finish;
  end
endmodule